// File: doc/BRIEF.md
# Speculative Branch History Manager

This block holds the speculative branch history used by a multi-table direction predictor. Global outcome history sits in a 256-entry bit ring and path history in a 32-entry bit ring. Beside them the block keeps a small set of folded global histories, which it compresses incrementally and updates as outcomes arrive, and a checkpoint table of pointer pairs. Each cycle the surrounding prediction logic supplies a fetch PC, up to two predicted directions, a valid-outcome count and the ring positions to write. The block stores the bits at those positions and advances every fold. It never works out a next pointer itself.

To recover from a misprediction, the caller saves the current pointer pair into one of 64 slots, keyed by fetch-queue slot. A later rollback names that slot. The restored pointers appear combinationally on the rollback outputs. On the next edge every fold is rebuilt from the live ring contents at the restored global pointer. Rings are never cleared on rollback, so bits written after the checkpoint that fall inside a fold's window take part in the rebuilt value.

Top module: `shm_hist_mgr`

## Requirements
- R1: On reset the global ring, path ring, all folds, every checkpoint slot and the last-saved pointer outputs are zero.
- R2: With a count of 1 (nbr_i = 2'd1), the global ring bit at gptr_i takes taken_i[0] on the next edge, and no other global ring bit changes.
- R3: With a count of 2 (nbr_i = 2'd2), position gptr_i takes taken_i[0] and position (gptr_i+1) mod 256 takes taken_i[1], so position 255 is followed by 0. A count of 3 is never presented.
- R4: With a nonzero count, the path ring bit at pptr_i takes pc_i[2] XOR pc_i[3]. Only one path bit is written per cycle.
- R5: With a count of 0 and no rollback, both rings and all folds keep their values whatever the other inputs do.
- R6: Fold i is FOLD_W bits wide and covers depth FOLD_BASE shifted left by i. It sits at fold_o[i*FOLD_W +: FOLD_W]. One step reads the leaving bit from ring position (pointer+depth) mod 256, taken before this cycle's write. The step then shifts the fold left by one and places new outcome XOR old top bit XOR leaving bit in bit 0.
- R7: With a count of 2, the step runs twice in one cycle. The first step uses taken_i[0] at gptr_i, and the second uses taken_i[1] at gptr_i+1.
- R8: save_en_i stores gptr_i and pptr_i into slot save_slot_i. rb_gptr_o and rb_pptr_o show the contents of slot rb_slot_i combinationally.
- R9: last_gptr_o and last_pptr_o show the pointer pair of the most recent save from the edge that stores it. A rollback does not change them.
- R10: After a rollback edge, fold i equals the XOR, over j from 0 to depth-1, of the ring bit at (restored pointer + j) mod 256 placed at fold bit j mod FOLD_W. The ring is read as it stands, including bits written after the checkpoint.
- R11: When rollback and a nonzero count arrive in the same cycle, the rollback wins and neither ring is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | PC_W | Fetch PC of the current prediction |
| taken_i | input | 2 | Predicted directions, slot 0 in bit 0 |
| nbr_i | input | 2 | Number of valid outcomes (0, 1 or 2) |
| gptr_i | input | 8 | Global ring write position, also the pointer saved |
| pptr_i | input | 5 | Path ring write position, also the pointer saved |
| save_en_i | input | 1 | Store the pointer pair into a checkpoint slot |
| save_slot_i | input | 6 | Checkpoint slot to store into |
| rb_en_i | input | 1 | Roll back and rebuild all folds |
| rb_slot_i | input | 6 | Checkpoint slot to restore from |
| ghist_o | output | 256 | Global ring contents |
| phist_o | output | 32 | Path ring contents |
| fold_o | output | NUM_FOLDS*FOLD_W | Folded global histories, fold 0 lowest |
| rb_gptr_o | output | 8 | Global pointer stored in slot rb_slot_i |
| rb_pptr_o | output | 5 | Path pointer stored in slot rb_slot_i |
| last_gptr_o | output | 8 | Global pointer of the most recent save |
| last_pptr_o | output | 5 | Path pointer of the most recent save |

## Verification
The properties assume that the outcome count never takes the value 3, and a dedicated check flags that input if it ever appears. The shift relations on the folds assume each fold is at least three bits wide and that every depth stays below 255, so the leaving bit never lands on a position written in the same cycle. Elaboration checks enforce both limits. The stimulus uses only counts 0 to 2 and the default fold shape, and it deliberately overlaps rollback with writes, with saves, and with a pointer wrapping at 255.

// File: rtl/shm_pkg.sv
package shm_pkg;

   localparam int unsigned SHM_GH_LEN   = 256;
   localparam int unsigned SHM_PH_LEN   = 32;
   localparam int unsigned SHM_CK_DEPTH = 64;

   typedef enum logic [1:0] {
      CNT_NONE = 2'd0,
      CNT_ONE  = 2'd1,
      CNT_TWO  = 2'd2,
      CNT_BAD  = 2'd3
   } br_cnt_e;

   // geometric depth series for the folded histories
   function automatic int unsigned fold_depth(input int unsigned base, input int unsigned idx);
      return base << idx;
   endfunction

endpackage

// File: rtl/shm_bitring.sv
module shm_bitring #(
   parameter int unsigned LEN = 256,
   parameter int unsigned PW  = $clog2(LEN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     wr_en,
   input  logic [PW-1:0]  wr_ptr,
   input  logic [1:0]     wr_bit,
   output logic [LEN-1:0] mem_o
);

   generate
      if ((1 << PW) != LEN) begin : g_len_bad
         $error("shm_bitring: LEN must be a power of two");
      end
   endgenerate

   logic [PW-1:0] ptr1;
   assign ptr1 = wr_ptr + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_o <= '0;
      end else begin
         if (wr_en[0]) mem_o[wr_ptr] <= wr_bit[0];
         if (wr_en[1]) mem_o[ptr1]   <= wr_bit[1];
      end
   end

   // R2
   slot0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[0] |=> mem_o[$past(wr_ptr)] == $past(wr_bit[0]));

   // R3
   slot1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[1] |=> mem_o[$past(ptr1)] == $past(wr_bit[1]));

   // R5
   ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == 2'b00) |=> $stable(mem_o));

endmodule

// File: rtl/shm_fold.sv
module shm_fold #(
   parameter int unsigned W   = 7,
   parameter int unsigned H   = 8,
   parameter int unsigned LEN = 256,
   parameter int unsigned PW  = $clog2(LEN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [LEN-1:0] mem_i,
   input  logic [PW-1:0]  ptr_i,
   input  logic [1:0]     steps_i,
   input  logic [1:0]     bits_i,
   input  logic           rb_en_i,
   input  logic [PW-1:0]  rb_ptr_i,
   output logic [W-1:0]   fold_o
);

   generate
      if (W < 3) begin : g_w_bad
         $error("shm_fold: W must be at least 3");
      end
      if (H + 2 > LEN) begin : g_h_bad
         $error("shm_fold: depth too large for the ring");
      end
   endgenerate

   localparam logic [PW-1:0] HOFS = PW'(H);

   function automatic logic [W-1:0] step(input logic [W-1:0] f, input logic nb, input logic ob);
      return {f[W-2:0], nb ^ f[W-1] ^ ob};
   endfunction

   logic [PW-1:0] out0_pos, out1_pos;
   logic [W-1:0]  f1, f2, acc, nxt;

   assign out0_pos = ptr_i + HOFS;
   assign out1_pos = ptr_i + HOFS + 1'b1;
   assign f1 = step(fold_o, bits_i[0], mem_i[out0_pos]);
   assign f2 = step(f1, bits_i[1], mem_i[out1_pos]);

   always_comb begin
      acc = '0;
      for (int unsigned j = 0; j < H; j++) begin
         acc[j % W] = acc[j % W] ^ mem_i[PW'(rb_ptr_i + PW'(j))];
      end
   end

   always_comb begin
      if (rb_en_i)               nxt = acc;
      else if (steps_i == 2'd2)  nxt = f2;
      else if (steps_i == 2'd1)  nxt = f1;
      else                       nxt = fold_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fold_o <= '0;
      else        fold_o <= nxt;
   end

   // R5
   fold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (steps_i == 2'd0 && !rb_en_i) |=> $stable(fold_o));

   // R6
   fold_shift1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (steps_i == 2'd1 && !rb_en_i) |=> fold_o[W-1:1] == $past(fold_o[W-2:0]));

   // R7
   fold_shift2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (steps_i == 2'd2 && !rb_en_i) |=> fold_o[W-1:2] == $past(fold_o[W-3:0]));

endmodule

// File: rtl/shm_ckpt.sv
module shm_ckpt #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned SW    = $clog2(DEPTH),
   parameter int unsigned GPW   = 8,
   parameter int unsigned PPW   = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           save_en_i,
   input  logic [SW-1:0]  save_slot_i,
   input  logic [GPW-1:0] save_gptr_i,
   input  logic [PPW-1:0] save_pptr_i,
   input  logic [SW-1:0]  rd_slot_i,
   output logic [GPW-1:0] rd_gptr_o,
   output logic [PPW-1:0] rd_pptr_o,
   output logic [GPW-1:0] last_gptr_o,
   output logic [PPW-1:0] last_pptr_o
);

   generate
      if ((1 << SW) != DEPTH) begin : g_depth_bad
         $error("shm_ckpt: DEPTH must be a power of two");
      end
   endgenerate

   logic [GPW-1:0] gtab [DEPTH];
   logic [PPW-1:0] ptab [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int unsigned k = 0; k < DEPTH; k++) begin
            gtab[k] <= '0;
            ptab[k] <= '0;
         end
         last_gptr_o <= '0;
         last_pptr_o <= '0;
      end else if (save_en_i) begin
         gtab[save_slot_i] <= save_gptr_i;
         ptab[save_slot_i] <= save_pptr_i;
         last_gptr_o       <= save_gptr_i;
         last_pptr_o       <= save_pptr_i;
      end
   end

   assign rd_gptr_o = gtab[rd_slot_i];
   assign rd_pptr_o = ptab[rd_slot_i];

   // R8
   slot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_en_i |=> (rd_slot_i != $past(save_slot_i)) ||
                    (rd_gptr_o == $past(save_gptr_i) && rd_pptr_o == $past(save_pptr_i)));

   // R9
   last_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_en_i |=> last_gptr_o == $past(save_gptr_i) && last_pptr_o == $past(save_pptr_i));

   // R9
   last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !save_en_i |=> $stable(last_gptr_o) && $stable(last_pptr_o));

endmodule

// File: rtl/shm_hist_mgr.sv
module shm_hist_mgr
   import shm_pkg::*;
#(
   parameter int unsigned PC_W      = 40,
   parameter int unsigned GH_LEN    = SHM_GH_LEN,
   parameter int unsigned PH_LEN    = SHM_PH_LEN,
   parameter int unsigned CK_DEPTH  = SHM_CK_DEPTH,
   parameter int unsigned NUM_FOLDS = 4,
   parameter int unsigned FOLD_W    = 7,
   parameter int unsigned FOLD_BASE = 8,
   localparam int unsigned GPW      = $clog2(GH_LEN),
   localparam int unsigned PPW      = $clog2(PH_LEN),
   localparam int unsigned SW       = $clog2(CK_DEPTH),
   localparam int unsigned FOLD_TOT = NUM_FOLDS * FOLD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PC_W-1:0]     pc_i,
   input  logic [1:0]          taken_i,
   input  logic [1:0]          nbr_i,
   input  logic [GPW-1:0]      gptr_i,
   input  logic [PPW-1:0]      pptr_i,
   input  logic                save_en_i,
   input  logic [SW-1:0]       save_slot_i,
   input  logic                rb_en_i,
   input  logic [SW-1:0]       rb_slot_i,
   output logic [GH_LEN-1:0]   ghist_o,
   output logic [PH_LEN-1:0]   phist_o,
   output logic [FOLD_TOT-1:0] fold_o,
   output logic [GPW-1:0]      rb_gptr_o,
   output logic [PPW-1:0]      rb_pptr_o,
   output logic [GPW-1:0]      last_gptr_o,
   output logic [PPW-1:0]      last_pptr_o
);

   generate
      if (PC_W < 4) begin : g_pc_bad
         $error("shm_hist_mgr: PC_W must reach bit 3");
      end
      if (NUM_FOLDS == 0) begin : g_nf_bad
         $error("shm_hist_mgr: at least one fold required");
      end
   endgenerate

   br_cnt_e    cnt;
   logic [1:0] steps;
   logic [1:0] g_wen, p_wen, p_bits;
   logic       path_bit;
   logic       pc_unused;

   assign cnt       = br_cnt_e'(nbr_i);
   assign path_bit  = pc_i[2] ^ pc_i[3];
   assign pc_unused = ^{pc_i[PC_W-1:4], pc_i[1:0]};

   always_comb begin
      steps = 2'd0;
      if (!rb_en_i) begin
         unique case (cnt)
            CNT_ONE: steps = 2'd1;
            CNT_TWO: steps = 2'd2;
            default: steps = 2'd0;
         endcase
      end
   end

   assign g_wen  = {steps == 2'd2, steps != 2'd0};
   assign p_wen  = {1'b0, steps != 2'd0};
   assign p_bits = {1'b0, path_bit};

   shm_bitring #(.LEN(GH_LEN)) u_gring (
      .clk(clk), .rst_n(rst_n), .wr_en(g_wen), .wr_ptr(gptr_i),
      .wr_bit(taken_i), .mem_o(ghist_o));

   shm_bitring #(.LEN(PH_LEN)) u_pring (
      .clk(clk), .rst_n(rst_n), .wr_en(p_wen), .wr_ptr(pptr_i),
      .wr_bit(p_bits), .mem_o(phist_o));

   shm_ckpt #(.DEPTH(CK_DEPTH), .GPW(GPW), .PPW(PPW)) u_ckpt (
      .clk(clk), .rst_n(rst_n),
      .save_en_i(save_en_i), .save_slot_i(save_slot_i),
      .save_gptr_i(gptr_i), .save_pptr_i(pptr_i),
      .rd_slot_i(rb_slot_i), .rd_gptr_o(rb_gptr_o), .rd_pptr_o(rb_pptr_o),
      .last_gptr_o(last_gptr_o), .last_pptr_o(last_pptr_o));

   generate
      for (genvar i = 0; i < NUM_FOLDS; i++) begin : g_fold
         localparam int unsigned FH = fold_depth(FOLD_BASE, i);
         shm_fold #(.W(FOLD_W), .H(FH), .LEN(GH_LEN)) u_fold (
            .clk(clk), .rst_n(rst_n), .mem_i(ghist_o), .ptr_i(gptr_i),
            .steps_i(steps), .bits_i(taken_i), .rb_en_i(rb_en_i),
            .rb_ptr_i(rb_gptr_o), .fold_o(fold_o[i*FOLD_W +: FOLD_W]));
      end
   endgenerate

   // R3
   cnt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nbr_i != 2'b11);

   // R11
   rb_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_en_i |=> $stable(ghist_o) && $stable(phist_o));

   // R9
   rb_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_en_i && !save_en_i) |=> $stable(last_gptr_o));

endmodule

// File: tb/shm_hist_mgr_tb_top.sv
module shm_hist_mgr_tb_top;

   localparam int FW = 7;
   localparam int NF = 4;

   typedef struct packed {
      logic [1:0] tk;
      logic [1:0] nb;
      logic [7:0] gp;
      logic [4:0] pp;
      logic [1:0] pc32;
      logic       xp;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{2'b01, 2'd1, 8'd0,  5'd0,  2'b01, 1'b1},
      '{2'b11, 2'd2, 8'd1,  5'd1,  2'b10, 1'b1},
      '{2'b10, 2'd2, 8'd3,  5'd2,  2'b11, 1'b0},
      '{2'b01, 2'd1, 8'd5,  5'd3,  2'b00, 1'b0},
      '{2'b00, 2'd0, 8'd6,  5'd4,  2'b01, 1'b1},
      '{2'b11, 2'd2, 8'd6,  5'd4,  2'b11, 1'b0},
      '{2'b01, 2'd2, 8'd8,  5'd5,  2'b10, 1'b1},
      '{2'b11, 2'd1, 8'd10, 5'd6,  2'b01, 1'b1},
      '{2'b10, 2'd1, 8'd11, 5'd7,  2'b00, 1'b0},
      '{2'b11, 2'd2, 8'd12, 5'd8,  2'b11, 1'b0},
      '{2'b01, 2'd2, 8'd14, 5'd9,  2'b01, 1'b1},
      '{2'b11, 2'd1, 8'd16, 5'd10, 2'b10, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] pc_r = '0;
   logic [1:0]  tk_r = '0, nb_r = '0;
   logic [7:0]  gp_r = '0;
   logic [4:0]  pp_r = '0;
   logic        se_r = 1'b0, re_r = 1'b0;
   logic [5:0]  ss_r = '0, rs_r = '0;

   logic [255:0]     ghist;
   logic [31:0]      phist;
   logic [NF*FW-1:0] fold;
   logic [7:0]       rb_g, last_g;
   logic [4:0]       rb_p, last_p;

   int checks = 0;
   int errors = 0;

   // reference state
   logic [255:0] gm;
   logic [31:0]  pm;
   logic [FW-1:0] fm [NF];
   logic [7:0]   ckg [64];
   logic [4:0]   ckp [64];
   logic [7:0]   lg;
   logic [4:0]   lp;

   always #2 clk = ~clk;

   shm_hist_mgr dut_i (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_r), .taken_i(tk_r), .nbr_i(nb_r),
      .gptr_i(gp_r), .pptr_i(pp_r), .save_en_i(se_r), .save_slot_i(ss_r),
      .rb_en_i(re_r), .rb_slot_i(rs_r), .ghist_o(ghist), .phist_o(phist),
      .fold_o(fold), .rb_gptr_o(rb_g), .rb_pptr_o(rb_p),
      .last_gptr_o(last_g), .last_pptr_o(last_p));

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] mstep(input logic [FW-1:0] f, input logic nb, input logic ob);
      return {f[FW-2:0], nb ^ f[FW-1] ^ ob};
   endfunction

   function automatic logic [FW-1:0] mrebuild(input int h, input int p);
      logic [FW-1:0] a = '0;
      for (int j = 0; j < h; j++) a[j % FW] ^= gm[(p + j) % 256];
      return a;
   endfunction

   function automatic logic [NF*FW-1:0] fpack();
      logic [NF*FW-1:0] v;
      for (int i = 0; i < NF; i++) v[i*FW +: FW] = fm[i];
      return v;
   endfunction

   task automatic mreset();
      gm = '0; pm = '0; lg = '0; lp = '0;
      for (int i = 0; i < NF; i++) fm[i] = '0;
      for (int k = 0; k < 64; k++) begin ckg[k] = '0; ckp[k] = '0; end
   endtask

   task automatic medge();
      logic [FW-1:0] nf [NF];
      for (int i = 0; i < NF; i++) begin
         int h = 8 << i;
         if (re_r) nf[i] = mrebuild(h, int'(ckg[rs_r]));
         else begin
            logic [FW-1:0] f = fm[i];
            if (nb_r != 2'd0) f = mstep(f, tk_r[0], gm[(int'(gp_r) + h) % 256]);
            if (nb_r == 2'd2) f = mstep(f, tk_r[1], gm[(int'(gp_r) + 1 + h) % 256]);
            nf[i] = f;
         end
      end
      if (!re_r && nb_r != 2'd0) begin
         gm[gp_r] = tk_r[0];
         pm[pp_r] = pc_r[2] ^ pc_r[3];
         if (nb_r == 2'd2) gm[(int'(gp_r) + 1) % 256] = tk_r[1];
      end
      if (se_r) begin ckg[ss_r] = gp_r; ckp[ss_r] = pp_r; lg = gp_r; lp = pp_r; end
      for (int i = 0; i < NF; i++) fm[i] = nf[i];
   endtask

   task automatic tick();
      medge();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic [1:0] tk, input logic [1:0] nb, input logic [7:0] gp,
                        input logic [4:0] pp, input logic [39:0] pc);
      tk_r = tk; nb_r = nb; gp_r = gp; pp_r = pp; pc_r = pc;
      se_r = 1'b0; re_r = 1'b0;
   endtask

   initial begin
      repeat (400) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      mreset();
      repeat (3) @(posedge clk);
      #1;
      rs_r = 6'd5;
      #1;
      // R1 reset state
      chk("R1 ghist", ghist, '0);
      chk("R1 phist", phist, '0);
      chk("R1 fold", fold, '0);
      chk("R1 last", {last_g, last_p}, '0);
      chk("R1 ckpt", {rb_g, rb_p}, '0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R6 R7
      foreach (VECS[v]) begin
         drive(VECS[v].tk, VECS[v].nb, VECS[v].gp, VECS[v].pp, {36'd0, VECS[v].pc32, 2'b00});
         tick();
         chk("R2/R3 ghist", ghist, gm);
         chk("R6/R7 fold", fold, fpack());
         if (VECS[v].nb != 2'd0) chk("R4 path bit", phist[VECS[v].pp], VECS[v].xp);
         chk("R4/R5 phist", phist, pm);
      end

      // R3 wrap at 255
      drive(2'b10, 2'd2, 8'd255, 5'd31, 40'h4);
      tick();
      chk("R3 wrap", {ghist[0], ghist[255]}, 2'b10);
      chk("R7 fold wrap", fold, fpack());

      // R5 idle with other inputs moving
      drive(2'b11, 2'd0, 8'd50, 5'd17, 40'hc);
      tick();
      chk("R5 ghist hold", ghist, gm);
      chk("R5 phist hold", phist, pm);
      chk("R5 fold hold", fold, fpack());

      // R8 R9 save
      drive(2'b00, 2'd0, 8'd20, 5'd11, 40'h0);
      se_r = 1'b1; ss_r = 6'd7;
      tick();
      chk("R9 last after save", {last_g, last_p}, {8'd20, 5'd11});
      se_r = 1'b0; rs_r = 6'd7;
      #1;
      chk("R8 slot read", {rb_g, rb_p}, {8'd20, 5'd11});

      // advance past the checkpoint
      for (int k = 0; k < 10; k++) begin
         drive(2'(k) ^ 2'b01, 2'd2, 8'(20 + 2 * k), 5'(11 + k), 40'(k * 4));
         tick();
         chk("R7 fill fold", fold, fpack());
      end
      chk("R3 fill ghist", ghist, gm);

      // second save with a simultaneous write
      drive(2'b01, 2'd1, 8'd40, 5'd21, 40'h8);
      se_r = 1'b1; ss_r = 6'd9;
      tick();
      chk("R9 last second save", {last_g, last_p}, {8'd40, 5'd21});
      chk("R2 ghist with save", ghist, gm);

      // R10 rollback to slot 7: stale bits inside windows count
      drive(2'b00, 2'd0, 8'd40, 5'd21, 40'h0);
      re_r = 1'b1; rs_r = 6'd7;
      #1;
      chk("R8 rollback pointer", {rb_g, rb_p}, {8'd20, 5'd11});
      tick();
      chk("R10 rebuilt fold", fold, fpack());
      chk("R9 last unchanged", {last_g, last_p}, {8'd40, 5'd21});

      // R11 rollback with a write in the same cycle
      drive(2'b11, 2'd2, 8'd100, 5'd3, 40'h4);
      re_r = 1'b1; rs_r = 6'd9;
      tick();
      chk("R11 ghist", ghist, gm);
      chk("R11 phist", phist, pm);
      chk("R11 fold rebuilt", fold, fpack());
      re_r = 1'b0;

      // R1 reset mid-run
      drive(2'b00, 2'd0, 8'd0, 5'd0, 40'h0);
      rst_n = 1'b0;
      rs_r = 6'd7;
      @(posedge clk);
      #1;
      mreset();
      chk("R1 ghist again", ghist, '0);
      chk("R1 phist again", phist, '0);
      chk("R1 fold again", fold, '0);
      chk("R1 last again", {last_g, last_p}, '0);
      chk("R1 slot cleared", {rb_g, rb_p}, '0);
      rst_n = 1'b1;

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule